// File: doc/BRIEF.md
# Station Address PROM Loader

This block fetches a network station address from a small byte-wide address PROM once after every reset. It walks eight PROM locations spaced sixteen bytes apart, mirrors the bit order of each returned byte, keeps the first six mirrored bytes as the 48-bit station address and folds all eight into an XOR checksum. The contents count as genuine only when that checksum comes out as 0xFF.

When the walk ends the block raises a sticky completion flag and reports whether the checksum held. The address output is all zeros until completion. It also stays all zeros after a failed checksum, so nothing downstream can act on a corrupt address. The PROM is modelled as a plain synchronous read port: a request in one cycle returns its byte in the next.

Top module: `sta_addr_loader`

## Requirements
- R1: While rstN is low, promRd, loadDone and addrValid are 0 and stationAddr is all zeros.
- R2: The first read request (promRd = 1, promAddr = 0) is issued in the first cycle after rstN rises. The eight requests come in eight consecutive cycles, each address 16 above the one before.
- R3: Exactly eight reads are issued after each reset, at byte offsets 16*k for k = 0..7. promRd stays 0 from then on until the next reset.
- R4: Each PROM byte is bit-mirrored before any use: bit i of the used value is bit 7-i of the byte read.
- R5: The mirrored byte from offset 0 lands in stationAddr[47:40]. Each following byte fills the next lower octet, and the byte from offset 80 lands in [7:0].
- R6: When the XOR of all eight mirrored bytes equals 0xFF, addrValid is 1 at completion and stationAddr carries the captured address.
- R7: When that XOR differs from 0xFF, addrValid is 0 at completion and stationAddr is all zeros.
- R8: loadDone rises exactly ten rising clock edges after rstN rises (counting the first edge after release as edge one). It stays 1 until the next reset.
- R9: While loadDone is 0, addrValid is 0 and stationAddr is all zeros.
- R10: promData is ignored in any cycle that does not directly follow a read request.
- R11: Asserting rstN low in the middle of a load abandons it, and the next release starts a complete fresh load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| promRd | output | 1 | PROM read request |
| promAddr | output | 7 | PROM byte address of the request |
| promData | input | 8 | PROM byte, valid the cycle after a request |
| stationAddr | output | 48 | Captured station address, byte 0 most significant |
| loadDone | output | 1 | Load finished (sticky until reset) |
| addrValid | output | 1 | Checksum passed; meaningful while loadDone is 1 |

## Verification
A wrong read index shows up on promAddr in the very cycle it is issued, and a stride or count fault is exposed before loadDone rises. A fault in the fold pipeline, such as sampling promData one cycle late or early, would fold the junk the bench drives between reads, so the checksum result or an address octet is wrong at the moment loadDone rises, ten edges after reset. A fault in the mirroring or the octet placement corrupts only stationAddr, and it is seen at that same completion cycle on a passing checksum.

// File: rtl/sta_addr_loader_pkg.sv
package sta_addr_loader_pkg;

  // Widest byte index the strobe bundle can carry.
  localparam int STROBE_IDX_W = 8;

  // Control to datapath strobes, one cycle each.
  typedef struct packed {
    logic                    foldEn;   // promData holds a requested byte
    logic [STROBE_IDX_W-1:0] foldIdx;  // which byte of the sequence it is
    logic                    finish;   // this fold is the last one
  } loadStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } loadState_t;

endpackage

// File: rtl/sta_bit_mirror.sv
module sta_bit_mirror #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : gMirror
    assign dataOut[b] = dataIn[WIDTH-1-b];
  end

endmodule

// File: rtl/sta_load_ctrl.sv
module sta_load_ctrl
  import sta_addr_loader_pkg::*;
#(
  parameter int BYTE_COUNT = 8,
  parameter int STRIDE     = 16,
  parameter int PROM_AW    = 7
) (
  input  logic               clk,
  input  logic               rstN,
  output logic               promRd,
  output logic [PROM_AW-1:0] promAddr,
  output loadStrobe_t        strobe
);

  localparam int IDX_W = (BYTE_COUNT > 1) ? $clog2(BYTE_COUNT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_COUNT - 1);

  loadState_t stateQ, stateD;
  logic [IDX_W-1:0] rdIdxQ;
  logic [IDX_W-1:0] foldIdxQ;
  logic             foldPendQ;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  stateD = ST_ISSUE;
      ST_ISSUE: if (rdIdxQ == LAST_IDX) stateD = ST_DRAIN;
      ST_DRAIN: stateD = ST_DONE;
      ST_DONE:  stateD = ST_DONE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      rdIdxQ <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_ISSUE && rdIdxQ != LAST_IDX) rdIdxQ <= rdIdxQ + 1'b1;
    end
  end

  // Track the request in flight: its byte arrives one cycle later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foldPendQ <= 1'b0;
      foldIdxQ  <= '0;
    end else begin
      foldPendQ <= (stateQ == ST_ISSUE);
      foldIdxQ  <= rdIdxQ;
    end
  end

  assign promRd   = (stateQ == ST_ISSUE);
  assign promAddr = PROM_AW'(int'(rdIdxQ) * STRIDE);

  assign strobe.foldEn  = foldPendQ;
  assign strobe.foldIdx = STROBE_IDX_W'(foldIdxQ);
  assign strobe.finish  = foldPendQ && (foldIdxQ == LAST_IDX);

endmodule

// File: rtl/sta_load_datapath.sv
module sta_load_datapath
  import sta_addr_loader_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int GOOD_SUM   = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [7:0]              promData,
  input  loadStrobe_t             strobe,
  output logic [8*ADDR_BYTES-1:0] stationAddr,
  output logic                    loadDone,
  output logic                    addrValid
);

  logic [7:0] mirrored;
  logic [7:0] sumQ;
  logic [7:0] sumNext;
  logic       doneQ;
  logic       validQ;
  logic [7:0] octetQ [ADDR_BYTES];
  logic [8*ADDR_BYTES-1:0] packedAddr;

  sta_bit_mirror #(.WIDTH(8)) uMirror (
    .dataIn  (promData),
    .dataOut (mirrored)
  );

  assign sumNext = sumQ ^ mirrored;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ   <= '0;
      doneQ  <= 1'b0;
      validQ <= 1'b0;
    end else if (strobe.foldEn) begin
      sumQ <= sumNext;
      if (strobe.finish) begin
        doneQ  <= 1'b1;
        validQ <= (sumNext == 8'(GOOD_SUM));
      end
    end
  end

  // One capture register per address octet; byte 0 is most significant.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : gOctet
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) octetQ[g] <= '0;
      else if (strobe.foldEn && strobe.foldIdx == STROBE_IDX_W'(g)) octetQ[g] <= mirrored;
    end
    assign packedAddr[8*(ADDR_BYTES-g)-1 -: 8] = octetQ[g];
  end

  assign stationAddr = (doneQ && validQ) ? packedAddr : '0;
  assign loadDone    = doneQ;
  assign addrValid   = doneQ && validQ;

endmodule

// File: rtl/sta_addr_loader.sv
module sta_addr_loader
  import sta_addr_loader_pkg::*;
#(
  parameter int BYTE_COUNT = 8,
  parameter int ADDR_BYTES = 6,
  parameter int STRIDE     = 16,
  localparam int PROM_AW   = $clog2(BYTE_COUNT * STRIDE),
  localparam int MAC_W     = 8 * ADDR_BYTES
) (
  input  logic               clk,
  input  logic               rstN,
  output logic               promRd,
  output logic [PROM_AW-1:0] promAddr,
  input  logic [7:0]         promData,
  output logic [MAC_W-1:0]   stationAddr,
  output logic               loadDone,
  output logic               addrValid
);

  loadStrobe_t strobe;

  sta_load_ctrl #(
    .BYTE_COUNT (BYTE_COUNT),
    .STRIDE     (STRIDE),
    .PROM_AW    (PROM_AW)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .promRd   (promRd),
    .promAddr (promAddr),
    .strobe   (strobe)
  );

  sta_load_datapath #(
    .ADDR_BYTES (ADDR_BYTES),
    .GOOD_SUM   (8'hFF)
  ) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .promData    (promData),
    .strobe      (strobe),
    .stationAddr (stationAddr),
    .loadDone    (loadDone),
    .addrValid   (addrValid)
  );

endmodule

// File: rtl/sta_addr_loader_chk.sv
module sta_addr_loader_chk #(
  parameter int BYTE_COUNT = 8,
  parameter int STRIDE     = 16,
  parameter int PROM_AW    = 7,
  parameter int MAC_W      = 48
) (
  input logic               clk,
  input logic               rstN,
  input logic               promRd,
  input logic [PROM_AW-1:0] promAddr,
  input logic [MAC_W-1:0]   stationAddr,
  input logic               loadDone,
  input logic               addrValid
);

  int rdCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdCount <= 0;
    else if (promRd) rdCount <= rdCount + 1;
  end

  AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    promRd |-> (int'(promAddr) % STRIDE) == 0); // R3

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (promRd && $past(promRd)) |-> int'(promAddr) == int'($past(promAddr)) + STRIDE); // R2

  AST_NO_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> !promRd); // R3

  AST_READ_TOTAL: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> rdCount == BYTE_COUNT); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone); // R8

  AST_QUIET_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !loadDone |-> (stationAddr == '0 && !addrValid)); // R9

  AST_BAD_SUM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && !addrValid) |-> stationAddr == '0); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |-> (!promRd && !loadDone && !addrValid)); // R1

endmodule

bind sta_addr_loader sta_addr_loader_chk #(
  .BYTE_COUNT (BYTE_COUNT),
  .STRIDE     (STRIDE),
  .PROM_AW    (PROM_AW),
  .MAC_W      (MAC_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .promRd      (promRd),
  .promAddr    (promAddr),
  .stationAddr (stationAddr),
  .loadDone    (loadDone),
  .addrValid   (addrValid)
);

// File: tb/sim_sta_addr_loader.sv
module sim_sta_addr_loader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        promRd;
  logic [6:0]  promAddr;
  logic [7:0]  promData;
  logic [47:0] stationAddr;
  logic        loadDone;
  logic        addrValid;

  logic [7:0] mem [128];
  int errors = 0;
  int checks = 0;
  int seed = 32'h5A17;

  always #2.5 clk = ~clk;

  sta_addr_loader u0 (
    .clk(clk), .rstN(rstN), .promRd(promRd), .promAddr(promAddr),
    .promData(promData), .stationAddr(stationAddr),
    .loadDone(loadDone), .addrValid(addrValid)
  );

  // PROM model: one-cycle latency, junk on the bus when no read was made (R10).
  always @(posedge clk) begin
    if (promRd) promData <= mem[promAddr];
    else        promData <= 8'($urandom);
  end

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Fill the PROM with junk, then place 8 raw bytes at the strided offsets.
  task automatic load_prom(input logic [7:0] raw [8]);
    for (int a = 0; a < 128; a++) mem[a] = 8'($urandom);
    for (int j = 0; j < 8; j++) mem[j*16] = raw[j];
  endtask

  task automatic run_load(input logic [7:0] raw [8], input string tag);
    logic [7:0]  sum;
    logic [47:0] expAddr;
    bit          expValid;
    sum = 8'h00;
    expAddr = '0;
    for (int j = 0; j < 8; j++) begin
      sum ^= rev8(raw[j]);
      if (j < 6) expAddr[47-8*j -: 8] = rev8(raw[j]);
    end
    expValid = (sum == 8'hFF);
    load_prom(raw);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!promRd && !loadDone && !addrValid && stationAddr == '0, "R1 reset state",
          {loadDone, addrValid, promRd}, 0);
    rstN = 1'b1;
    for (int e = 1; e <= 10; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e <= 8) begin
        check(promRd == 1'b1 && promAddr == 7'((e-1)*16), "R2 R3 read sequence",
              {promRd, promAddr}, {1'b1, 7'((e-1)*16)});
      end else begin
        check(!promRd, "R3 no extra read", promRd, 0);
      end
      if (e < 10) begin
        check(!loadDone && !addrValid && stationAddr == '0, "R9 quiet before done",
              {loadDone, addrValid, stationAddr}, 0);
      end
    end
    check(loadDone == 1'b1, "R8 done on tenth edge", loadDone, 1);
    check(addrValid == expValid, expValid ? "R6 valid flag" : "R7 invalid flag",
          addrValid, expValid);
    if (expValid) check(stationAddr == expAddr, "R4 R5 address", stationAddr, expAddr);
    else          check(stationAddr == '0, "R7 address zeroed", stationAddr, 0);
    repeat (3) @(negedge clk);
    check(loadDone && !promRd, "R8 done sticky", {loadDone, promRd}, 2);
    check(stationAddr == (expValid ? expAddr : 48'h0), "R8 address held", stationAddr, expAddr);
    if (tag.len() > 0) ;
  endtask

  task automatic make_valid(output logic [7:0] raw [8]);
    logic [7:0] s;
    s = 8'h00;
    for (int j = 0; j < 7; j++) begin
      raw[j] = 8'($urandom);
      s ^= rev8(raw[j]);
    end
    raw[7] = rev8(8'hFF ^ s);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    logic [7:0] raw [8];
    void'($urandom(seed));
    promData = 8'h00;
    for (int a = 0; a < 128; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    check(!promRd && !loadDone && !addrValid && stationAddr == '0, "R1 initial reset",
          {loadDone, addrValid, promRd}, 0);

    // R4 R5: one-hot bytes show mirroring and octet order; byte 7 balances the sum.
    raw = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h00, 8'h00};
    raw[7] = rev8(8'hFF ^ 8'h80 ^ 8'h40 ^ 8'h20 ^ 8'h10 ^ 8'h08 ^ 8'h04);
    run_load(raw, "onehot");

    // R7: all-0xFF bytes fold to 0x00.
    raw = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run_load(raw, "allff");

    // R6: only byte 7 carries the checksum, address all zeros.
    raw = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF};
    run_load(raw, "zeroaddr");

    // R7: a single-bit error against a valid set.
    make_valid(raw);
    raw[3] ^= 8'h10;
    run_load(raw, "bitflip");

    // R11: abandon a load midway, then a full fresh load.
    make_valid(raw);
    load_prom(raw);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!promRd && !loadDone && stationAddr == '0, "R11 R1 mid-load reset",
          {promRd, loadDone}, 0);
    run_load(raw, "restart");

    // Random mix of valid and corrupted contents.
    for (int t = 0; t < 16; t++) begin
      make_valid(raw);
      if (t % 2 == 1) raw[$urandom % 8] ^= 8'(1 << ($urandom % 8));
      run_load(raw, "random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule